// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a two-wire serial memory's protocol engine and its storage array. While a write transaction is in progress it gathers data bytes into a small page-sized holding buffer. A per-byte valid mask records which slots of the page were actually received. Nothing reaches the array while the bytes arrive. When the protocol engine reports the stop condition that ends the write, the block walks the buffer and writes every received byte into the array. It then holds a busy flag for a programmable self-timed interval.

The protocol engine loads the starting word address once per transaction, strobes each accepted data byte, and signals the stop event. The running address advances only within its low three bits, so the write never leaves its page row. Writing more than a page's worth of bytes wraps to the start of the same row, and the later bytes replace the earlier ones. The running address doubles as the shared word-address counter. After a commit it points one past the last written byte, wrapped within the page. A write-protect input, sampled at the stop, suppresses every array write but leaves the rest of the sequence unchanged.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy` and `memWe` are low and `curAddr` is 0.
- R2: A pulse on `addrLoad` sets `curAddr` to `addrIn` on the next cycle. Each accepted byte then adds one to `curAddr[2:0]` modulo 8, and `curAddr[7:3]` never changes.
- R3: When more than 8 bytes are sent in one transaction, the slot index wraps inside the same page. The array ends up holding, for each slot, the last byte sent to that slot.
- R4: Partial pages are supported. Only slots that received a byte in the transaction are written, so the number of `memWe` pulses equals the number of distinct slots filled.
- R5: No `memWe` pulse occurs before the stop. All array writes of a commit happen within the 8 cycles that follow the cycle in which `stopEvt` was sampled. Each write goes to address `{page, slot}`.
- R6: A stop that ends a transaction holding at least one byte raises `busy` on the next cycle. `busy` then stays high for exactly `8 + CYCLE_CLKS` cycles.
- R7: While `busy` is high, the block ignores `addrLoad`, `byteValid` and `stopEvt`. `curAddr` does not change, and no later commit picks up those bytes.
- R8: If `wpIn` is high in the cycle the stop is sampled, there is no `memWe` pulse and the array is unchanged. `busy` still runs its full length, and `curAddr` still reflects the bytes received.
- R9: A stop that arrives when no byte has been received since the last address load or commit produces no `memWe` and does not raise `busy`.
- R10: After a commit, `curAddr` equals the address of the last received byte plus one, with the carry kept inside the low three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Load `addrIn` as the start of a new write transaction |
| addrIn | input | 8 | Starting word address |
| byteValid | input | 1 | One-cycle strobe: `byteData` holds an accepted data byte |
| byteData | input | 8 | Data byte from the protocol engine |
| stopEvt | input | 1 | One-cycle strobe: stop condition seen |
| wpIn | input | 1 | Write protect, sampled with the stop |
| busy | output | 1 | Commit walk or self-timed interval in progress |
| curAddr | output | 8 | Shared word-address counter |
| memWe | output | 1 | Array write enable |
| memAddr | output | 8 | Array write address |
| memWdata | output | 8 | Array write data |

## Verification
The assertions rely on the protocol engine never raising `addrLoad` and `byteValid` in the same cycle. They also assume every strobe lasts exactly one clock, which keeps the empty-stop and busy-entry properties unambiguous. The directed stimulus drives each strobe for a single cycle on the falling edge and never combines an address load with a byte. It deliberately fires all three strobes and toggles write protect while `busy` is high, since the block must tolerate those inputs there.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic loadAddr;   // take a new start address, drop pending slots
    logic takeByte;   // store byteData at the running slot
    logic commitGo;   // stop accepted with pending data: latch protect
    logic walkActive; // commit walk is visiting one slot per cycle
    logic endWalk;    // last slot of the walk this cycle
  } pwbStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WALK,
    PH_HOLD
  } pwbPhase_t;

endpackage

// File: rtl/pwb_control.sv
module pwb_control
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int CYCLE_CLKS = 2000,
  localparam int SLOT_W  = $clog2(PAGE_BYTES),
  localparam int TIMER_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic              byteValid,
  input  logic              stopEvt,
  input  logic              havePending,
  output pwbStrobes_t       strobes,
  output logic [SLOT_W-1:0] walkIdx,
  output logic              busy
);

  localparam logic [SLOT_W-1:0]  LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);
  localparam logic [SLOT_W-1:0]  SLOT_ONE  = SLOT_W'(1);
  localparam logic [TIMER_W-1:0] HOLD_LOAD = TIMER_W'(CYCLE_CLKS - 1);
  localparam logic [TIMER_W-1:0] TIMER_ONE = TIMER_W'(1);

  pwbPhase_t          phase;
  logic [TIMER_W-1:0] holdCnt;
  logic               isIdle;

  assign isIdle = (phase == PH_IDLE);
  assign busy   = !isIdle;

  always_comb begin
    strobes            = '0;
    strobes.loadAddr   = isIdle && addrLoad;
    strobes.takeByte   = isIdle && byteValid && !addrLoad;
    strobes.commitGo   = isIdle && stopEvt && !addrLoad && (havePending || byteValid);
    strobes.walkActive = (phase == PH_WALK);
    strobes.endWalk    = (phase == PH_WALK) && (walkIdx == LAST_SLOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      walkIdx <= '0;
      holdCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (strobes.commitGo) begin
            phase   <= PH_WALK;
            walkIdx <= '0;
          end
        end
        PH_WALK: begin
          if (strobes.endWalk) begin
            phase   <= PH_HOLD;
            holdCnt <= HOLD_LOAD;
          end else begin
            walkIdx <= walkIdx + SLOT_ONE;
          end
        end
        PH_HOLD: begin
          if (holdCnt == '0) phase <= PH_IDLE;
          else               holdCnt <= holdCnt - TIMER_ONE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  localparam int SLOT_W = $clog2(PAGE_BYTES),
  localparam int ROW_W  = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobes_t       strobes,
  input  logic [SLOT_W-1:0] walkIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] byteData,
  input  logic              wpIn,
  output logic              havePending,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

  logic [ROW_W-1:0]  rowPtr;
  logic [SLOT_W-1:0] slotPtr;
  logic [DATA_W-1:0] slotData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;
  logic              wpHeld;

  assign curAddr = {rowPtr, slotPtr};

  // Running address: row fixed, slot wraps inside the page
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowPtr  <= '0;
      slotPtr <= '0;
    end else if (strobes.loadAddr) begin
      rowPtr  <= addrIn[ADDR_W-1:SLOT_W];
      slotPtr <= addrIn[SLOT_W-1:0];
    end else if (strobes.takeByte) begin
      slotPtr <= slotPtr + SLOT_ONE;
    end
  end

  // One storage slot per byte of the page
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotData[i]  <= '0;
        slotValid[i] <= 1'b0;
      end else if (strobes.takeByte && (slotPtr == SLOT_W'(i))) begin
        slotData[i]  <= byteData;
        slotValid[i] <= 1'b1;
      end else if (strobes.loadAddr || strobes.endWalk) begin
        slotValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 wpHeld <= 1'b0;
    else if (strobes.commitGo) wpHeld <= wpIn;
  end

  assign havePending = |slotValid;
  assign memWe    = strobes.walkActive && slotValid[walkIdx] && !wpHeld;
  assign memAddr  = {rowPtr, walkIdx};
  assign memWdata = slotData[walkIdx];

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int CYCLE_CLKS = 2000,
  localparam int SLOT_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopEvt,
  input  logic              wpIn,
  output logic              busy,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  pwbStrobes_t       strobes;
  logic [SLOT_W-1:0] walkIdx;
  logic              havePending;

  pwb_control #(
    .PAGE_BYTES(PAGE_BYTES),
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .addrLoad   (addrLoad),
    .byteValid  (byteValid),
    .stopEvt    (stopEvt),
    .havePending(havePending),
    .strobes    (strobes),
    .walkIdx    (walkIdx),
    .busy       (busy)
  );

  pwb_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .walkIdx    (walkIdx),
    .addrIn     (addrIn),
    .byteData   (byteData),
    .wpIn       (wpIn),
    .havePending(havePending),
    .curAddr    (curAddr),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/page_write_buffer_checker.sv
module page_write_buffer_checker #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int CYCLE_CLKS = 2000,
  localparam int SLOT_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic              byteValid,
  input logic              stopEvt,
  input logic              wpIn,
  input logic              busy,
  input logic [ADDR_W-1:0] curAddr,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  logic [31:0] busyRun;
  logic        gotByte;
  logic        wpSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyRun <= '0;
      gotByte <= 1'b0;
      wpSeen  <= 1'b0;
    end else begin
      busyRun <= busy ? busyRun + 32'd1 : 32'd0;
      if (busy)                               gotByte <= 1'b0;
      else if (addrLoad)                      gotByte <= 1'b0;
      else if (byteValid)                     gotByte <= 1'b1;
      else if (stopEvt)                       gotByte <= 1'b0;
      if (!busy && stopEvt)                   wpSeen  <= wpIn;
    end
  end

  // R5: array writes only inside a commit
  p_we_in_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R2: successive writes of one commit stay on one page row
  p_same_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr[ADDR_W-1:SLOT_W] == $past(memAddr[ADDR_W-1:SLOT_W])));

  // R6: busy length is the walk plus the timed interval
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 32'(PAGE_BYTES + CYCLE_CLKS)));

  // R6: busy only follows a stop
  p_busy_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt));

  // R7: inputs during busy leave the counter alone
  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curAddr));

  // R8: write protect at the stop blocks all array writes
  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !wpSeen);

  // R9: empty stop starts nothing
  p_empty_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEvt && !gotByte && !byteValid) |=> !busy);

endmodule

bind page_write_buffer page_write_buffer_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES),
  .CYCLE_CLKS(CYCLE_CLKS)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .addrLoad (addrLoad),
  .byteValid(byteValid),
  .stopEvt  (stopEvt),
  .wpIn     (wpIn),
  .busy     (busy),
  .curAddr  (curAddr),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 20;
  localparam int BUSY_LEN   = 8 + CYC;

  logic       clk = 1'b0;
  logic       rstN;
  logic       addrLoad, byteValid, stopEvt, wpIn;
  logic [7:0] addrIn, byteData;
  logic       busy, memWe;
  logic [7:0] curAddr, memAddr, memWdata;

  int  total = 0;
  int  bad   = 0;
  int  weCount = 0;
  bit  finished = 1'b0;
  logic [7:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_buffer #(.CYCLE_CLKS(CYC)) u_page_write_buffer (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .byteValid(byteValid), .byteData(byteData), .stopEvt(stopEvt), .wpIn(wpIn),
    .busy(busy), .curAddr(curAddr), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  // Array model fed by the write port
  always @(posedge clk) begin
    if (rstN && memWe) begin
      model[memAddr] <= memWdata;
      weCount <= weCount + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic loadAddr(input logic [7:0] a);
    @(negedge clk); addrLoad = 1'b1; addrIn = a;
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    @(negedge clk); byteValid = 1'b0;
  endtask

  // Issues a stop and returns the number of cycles busy stayed high
  task automatic stopAndWait(output int len);
    @(negedge clk); stopEvt = 1'b1;
    @(negedge clk); stopEvt = 1'b0;
    len = 0;
    for (int k = 0; k < 5000 && busy; k++) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rstN = 1'b0; addrLoad = 0; byteValid = 0; stopEvt = 0; wpIn = 0;
    addrIn = 0; byteData = 0;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 memWe", int'(memWe), 0);
    check("R1 curAddr", int'(curAddr), 0);
    rstN = 1'b1;
  endtask

  task automatic t_byte_write;
    int len; int base;
    base = weCount;
    loadAddr(8'h25);
    check("R2 load", int'(curAddr), 8'h25);
    sendByte(8'hA1);
    check("R2 step", int'(curAddr), 8'h26);
    repeat (3) @(negedge clk);
    check("R5 nothing before stop", weCount - base, 0);
    stopAndWait(len);
    check("R6 busy length", len, BUSY_LEN);
    check("R4 single write count", weCount - base, 1);
    check("R5 byte landed", int'(model[8'h25]), 8'hA1);
    check("R10 counter after commit", int'(curAddr), 8'h26);
  endtask

  task automatic t_page_wrap;
    int len; int base;
    base = weCount;
    loadAddr(8'h3E);
    for (int i = 0; i < 10; i++) begin
      sendByte(8'hC0 + 8'(i));
      check("R2 row fixed", int'(curAddr[7:3]), 8'h3E >> 3);
    end
    check("R2 slot wrapped", int'(curAddr), 8'h38);
    stopAndWait(len);
    check("R3 write count", weCount - base, 8);
    check("R3 slot6 overwritten", int'(model[8'h3E]), 8'hC8);
    check("R3 slot7 overwritten", int'(model[8'h3F]), 8'hC9);
    check("R3 slot0", int'(model[8'h38]), 8'hC2);
    check("R3 slot5", int'(model[8'h3D]), 8'hC7);
    check("R3 next page untouched", int'(model[8'h40]), 0);
    check("R10 wrapped counter", int'(curAddr), 8'h38);
  endtask

  task automatic t_partial;
    int len; int base;
    loadAddr(8'h40);
    for (int i = 0; i < 8; i++) sendByte(8'h10 + 8'(i));
    stopAndWait(len);
    base = weCount;
    loadAddr(8'h42);
    sendByte(8'hE2);
    sendByte(8'hE3);
    stopAndWait(len);
    check("R4 partial write count", weCount - base, 2);
    check("R4 slot2 new", int'(model[8'h42]), 8'hE2);
    check("R4 slot3 new", int'(model[8'h43]), 8'hE3);
    check("R4 slot1 kept", int'(model[8'h41]), 8'h11);
    check("R4 slot4 kept", int'(model[8'h44]), 8'h14);
    check("R10 partial counter", int'(curAddr), 8'h44);
  endtask

  task automatic t_busy_ignore;
    int base; int len;
    loadAddr(8'h80);
    sendByte(8'h5A);
    @(negedge clk); stopEvt = 1'b1;
    @(negedge clk); stopEvt = 1'b0;
    check("R6 busy next cycle", int'(busy), 1);
    addrLoad = 1'b1; addrIn = 8'h90;
    @(negedge clk); addrLoad = 1'b0; byteValid = 1'b1; byteData = 8'hFF;
    @(negedge clk); byteValid = 1'b0; stopEvt = 1'b1; wpIn = 1'b1;
    @(negedge clk); stopEvt = 1'b0; wpIn = 1'b0;
    check("R7 counter held", int'(curAddr), 8'h81);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    base = weCount;
    check("R7 counter after busy", int'(curAddr), 8'h81);
    check("R7 slot not hit", int'(model[8'h81]), 0);
    check("R8 late protect ignored", int'(model[8'h80]), 8'h5A);
    stopAndWait(len);
    check("R7 ignored bytes not pending", len, 0);
    check("R7 no stray write", weCount - base, 0);
  endtask

  task automatic t_protect;
    int len; int base;
    base = weCount;
    loadAddr(8'h25);
    sendByte(8'h77);
    sendByte(8'h78);
    @(negedge clk); wpIn = 1'b1; stopEvt = 1'b1;
    @(negedge clk); stopEvt = 1'b0; wpIn = 1'b0;
    len = 0;
    for (int k = 0; k < 5000 && busy; k++) begin len++; @(negedge clk); end
    check("R8 no writes", weCount - base, 0);
    check("R8 array kept", int'(model[8'h25]), 8'hA1);
    check("R8 busy still runs", len, BUSY_LEN);
    check("R8 counter advanced", int'(curAddr), 8'h27);
  endtask

  task automatic t_empty_stop;
    int len; int base;
    base = weCount;
    loadAddr(8'hC3);
    stopAndWait(len);
    check("R9 no busy", len, 0);
    repeat (10) @(negedge clk);
    check("R9 still idle", int'(busy), 0);
    check("R9 no writes", weCount - base, 0);
    check("R9 counter kept", int'(curAddr), 8'hC3);
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_partial();
    t_busy_ignore();
    t_protect();
    t_empty_stop();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

endmodule